// File: doc/BRIEF.md
# Stack Access Queue with Offset Forwarding and Pair Combining

This block buffers in-flight local-variable loads and stores in front of a small local-variable cache. Each access enters with its stack-pointer-relative byte offset already known, so dependences between queued accesses are resolved by comparing offsets instead of full addresses. A load whose offset matches a store already in the queue takes its data from that store. The load returns on a result port one cycle later and never reaches the cache.

Every other access waits in program order and leaves from the head of the queue on a single cache request port. When the two oldest entries are of the same kind and the second sits exactly one 4-byte word above the first, both go out as one request. That request carries two data words and a pair flag, which saves cache port bandwidth. A flush input removes every entry younger than a given tag, for example after a branch misprediction. Loads that go to the cache return their data through the cache, not through this block.

Top module: `stack_access_queue`

## Requirements
- R1: After reset the queue is empty: `full`, `req_valid` and `res_valid` are all low.
- R2: An accepted load whose offset equals that of a store held in the queue raises `res_valid` on the next cycle, with the load's tag on `res_tag` and that store's data on `res_data`. The load is not queued. `res_valid` is never high except in the cycle after such a load.
- R3: When several queued stores match the load's offset, the data comes from the youngest of them.
- R4: A load that matches no queued store produces no result and is queued. Its data field is stored as zero. It later appears on the request port with `req_is_store` low.
- R5: Requests leave in program order. `req_valid` is high whenever the queue is non-empty and no flush is present, and it shows the oldest entry. An entry stays at the head unchanged until `cache_ready` is high.
- R6: `req_pair` is high only when the head and the next entry are both loads or both stores, and the next entry's offset is the head's offset plus 4. A descending pair or a mixed pair is sent as two single requests. In a pair, `req_data1` and `req_tag1` belong to the second entry; otherwise they are zero.
- R7: A request never carries more than two accesses. Three ascending adjacent stores leave as a pair followed by a single request.
- R8: `full` is high when 8 entries are held. An enqueue offered while `full` is high is dropped and never reaches the request port.
- R9: While `flush_valid` is high, entries whose tag is younger than `flush_tag` are removed. Tags are compared as 6-bit wrap-around differences, and an entry is younger when the difference is positive. In that cycle `req_valid` is low, no request is accepted and any enqueue is dropped.
- R10: A load can still forward from a store that is leaving the queue to the cache in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_is_store | input | 1 | 1 = store, 0 = load |
| enq_off | input | 12 | Stack-pointer-relative byte offset |
| enq_data | input | 32 | Store data (ignored for loads) |
| enq_tag | input | 6 | Program-order tag |
| full | output | 1 | Queue holds 8 entries; enqueue is dropped |
| res_valid | output | 1 | Forwarded load result valid |
| res_tag | output | 6 | Tag of the forwarded load |
| res_data | output | 32 | Forwarded data |
| req_valid | output | 1 | Cache request valid |
| req_is_store | output | 1 | Request kind |
| req_off | output | 12 | Offset of the first word |
| req_pair | output | 1 | Request carries two adjacent words |
| req_data0 | output | 32 | First word data |
| req_data1 | output | 32 | Second word data when paired |
| req_tag0 | output | 6 | First access tag |
| req_tag1 | output | 6 | Second access tag when paired |
| cache_ready | input | 1 | Cache accepts the request this cycle |
| flush_valid | input | 1 | Flush younger entries |
| flush_tag | input | 6 | Flush boundary tag |

## Verification
Forwarding and issue can fall in the same cycle. An incoming load can match a store that the cache is accepting at that edge. The bench provokes this by placing a lone store at the head with `cache_ready` held high and offering a matching load on the next cycle. It then judges that the result arrives with the store's data while the load never shows up as a request. Flush meeting an offered enqueue and a waiting request is the second collision. Long random traffic, compared every cycle against a behavioural queue model, hits both collisions many more times.

// File: rtl/saq_pkg.sv
// Package: shared kinds and constants of the stack access queue.
// Assumes byte offsets and 4-byte words.
package saq_pkg;
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/saq_fwd_scan.sv
// Forwarding search: among live queued entries in age order (index 0 oldest),
// finds the youngest store whose offset equals look_off.
// Assumes the age view is a contiguous prefix of live entries.
module saq_fwd_scan #(
    parameter int DEPTH = 8,
    parameter int OFFW  = 12,
    parameter int DW    = 32
) (
    input  logic [DEPTH-1:0] age_live,
    input  logic [DEPTH-1:0] age_st,
    input  logic [OFFW-1:0]  age_off [DEPTH],
    input  logic [DW-1:0]    age_data [DEPTH],
    input  logic [OFFW-1:0]  look_off,
    output logic             hit,
    output logic [DW-1:0]    hit_data
);
    logic [DEPTH-1:0] match;

    // Per-entry offset comparators.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = age_live[g] && age_st[g] && (age_off[g] == look_off);
    end

    // Youngest match wins: later indices override earlier ones.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_data = age_data[i];
            end
        end
    end
endmodule

// File: rtl/saq_pair_pick.sv
// Combining decision: the two oldest entries form one request when both are
// live, of the same kind, and the second sits one word above the first.
module saq_pair_pick #(
    parameter int OFFW = 12
) (
    input  logic            live0,
    input  logic            live1,
    input  logic            st0,
    input  logic            st1,
    input  logic [OFFW-1:0] off0,
    input  logic [OFFW-1:0] off1,
    output logic            pair
);
    import saq_pkg::*;

    logic [OFFW-1:0] next_word;

    // Offset of the word directly above the head.
    assign next_word = off0 + OFFW'(WORD_BYTES);

    // Same kind, ascending adjacency, both present.
    assign pair = live0 && live1 && (st0 == st1) && (off1 == next_word);
endmodule

// File: rtl/saq_flush_trim.sv
// Flush trimming: counts how many of the oldest live entries survive a flush
// at cut_tag. Assumes tags rise in program order and never span half the tag space.
module saq_flush_trim #(
    parameter int DEPTH = 8,
    parameter int TAGW  = 6,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cut_valid,
    input  logic [DEPTH-1:0]  age_live,
    input  logic [TAGW-1:0]   age_tag [DEPTH],
    input  logic [TAGW-1:0]   cut_tag,
    output logic [CW-1:0]     keep_cnt
);
    logic [DEPTH-1:0] keep;

    // Survivor mask: live and not younger than the cut tag.
    for (genvar g = 0; g < DEPTH; g++) begin : g_keep
        logic [TAGW-1:0] diff;
        assign diff    = age_tag[g] - cut_tag;
        assign keep[g] = age_live[g] && (diff[TAGW-1] || (diff == '0));
    end

    // Population count of survivors.
    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            keep_cnt = keep_cnt + CW'(keep[i]);
        end
    end

    AST_FLUSH_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        cut_valid |-> (((keep + DEPTH'(1)) & keep) == '0)); // R9
endmodule

// File: rtl/stack_access_queue.sv
// Stack access queue: holds local-variable loads and stores in program order,
// forwards store data to younger loads by offset match, and issues to the cache
// from the head, pairing two adjacent same-kind words. DEPTH must be a power of two.
module stack_access_queue #(
    parameter int DEPTH = 8,
    parameter int OFFW  = 12,
    parameter int DW    = 32,
    parameter int TAGW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enq_valid,
    input  logic            enq_is_store,
    input  logic [OFFW-1:0] enq_off,
    input  logic [DW-1:0]   enq_data,
    input  logic [TAGW-1:0] enq_tag,
    output logic            full,
    output logic            res_valid,
    output logic [TAGW-1:0] res_tag,
    output logic [DW-1:0]   res_data,
    output logic            req_valid,
    output logic            req_is_store,
    output logic [OFFW-1:0] req_off,
    output logic            req_pair,
    output logic [DW-1:0]   req_data0,
    output logic [DW-1:0]   req_data1,
    output logic [TAGW-1:0] req_tag0,
    output logic [TAGW-1:0] req_tag1,
    input  logic            cache_ready,
    input  logic            flush_valid,
    input  logic [TAGW-1:0] flush_tag
);
    import saq_pkg::*;

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [PW-1:0]   head;
    logic [CW-1:0]   occ;
    acc_kind_e       slot_kind [DEPTH];
    logic [OFFW-1:0] slot_off  [DEPTH];
    logic [DW-1:0]   slot_data [DEPTH];
    logic [TAGW-1:0] slot_tag  [DEPTH];

    logic [DEPTH-1:0] age_live;
    logic [DEPTH-1:0] age_st;
    logic [OFFW-1:0]  age_off  [DEPTH];
    logic [DW-1:0]    age_data [DEPTH];
    logic [TAGW-1:0]  age_tag  [DEPTH];

    logic            fwd_hit;
    logic [DW-1:0]   fwd_data;
    logic            pair_ok;
    logic [CW-1:0]   keep_cnt;
    logic            enq_fire;
    logic            push;
    logic            req_fire;
    logic [CW-1:0]   pop;
    logic [PW-1:0]   tail;

    // Age-ordered view of the circular storage, index 0 at the head.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW-1:0] phys;
        assign phys        = head + PW'(g);
        assign age_live[g] = (CW'(g) < occ);
        assign age_st[g]   = (slot_kind[phys] == ACC_STORE);
        assign age_off[g]  = slot_off[phys];
        assign age_data[g] = slot_data[phys];
        assign age_tag[g]  = slot_tag[phys];
    end

    saq_fwd_scan #(.DEPTH(DEPTH), .OFFW(OFFW), .DW(DW)) u_scan (
        .age_live (age_live),
        .age_st   (age_st),
        .age_off  (age_off),
        .age_data (age_data),
        .look_off (enq_off),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    saq_pair_pick #(.OFFW(OFFW)) u_pair (
        .live0 (age_live[0]),
        .live1 (age_live[1]),
        .st0   (age_st[0]),
        .st1   (age_st[1]),
        .off0  (age_off[0]),
        .off1  (age_off[1]),
        .pair  (pair_ok)
    );

    saq_flush_trim #(.DEPTH(DEPTH), .TAGW(TAGW)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .cut_valid (flush_valid),
        .age_live  (age_live),
        .age_tag   (age_tag),
        .cut_tag   (flush_tag),
        .keep_cnt  (keep_cnt)
    );

    // Occupancy flag, acceptance and push/pop decisions.
    assign full     = (occ == CW'(DEPTH));
    assign enq_fire = enq_valid && !full && !flush_valid;
    assign push     = enq_fire && (enq_is_store || !fwd_hit);
    assign req_fire = req_valid && cache_ready;
    assign pop      = req_fire ? (req_pair ? CW'(2) : CW'(1)) : '0;
    assign tail     = head + occ[PW-1:0];

    // Head request outputs, gated off during a flush.
    assign req_valid    = age_live[0] && !flush_valid;
    assign req_is_store = age_st[0];
    assign req_off      = age_off[0];
    assign req_data0    = age_data[0];
    assign req_tag0     = age_tag[0];
    assign req_pair     = req_valid && pair_ok;
    assign req_data1    = req_pair ? age_data[1] : '0;
    assign req_tag1     = req_pair ? age_tag[1]  : '0;

    // Entry write at the tail; load data is stored as zero.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_kind[tail] <= enq_is_store ? ACC_STORE : ACC_LOAD;
            slot_off[tail]  <= enq_off;
            slot_data[tail] <= enq_is_store ? enq_data : '0;
            slot_tag[tail]  <= enq_tag;
        end
    end

    // Head pointer and occupancy update, flush takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            occ  <= '0;
        end else if (flush_valid) begin
            occ  <= keep_cnt;
        end else begin
            head <= head + PW'(pop);
            occ  <= occ - pop + CW'(push);
        end
    end

    // Forwarded load result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_tag   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= enq_fire && !enq_is_store && fwd_hit;
            res_tag   <= enq_tag;
            res_data  <= fwd_data;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R8

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !req_fire && !flush_valid) |=> full); // R8

    AST_RES_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(enq_valid && !enq_is_store)); // R2

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cache_ready && !flush_valid) |=>
        (flush_valid || (req_valid && req_tag0 == $past(req_tag0)))); // R5

    AST_PAIR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pair) |-> (occ >= CW'(2))); // R7

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !res_valid); // R9
endmodule

// File: tb/sim_stack_access_queue.sv
module sim_stack_access_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic        enq_is_store = 1'b0;
    logic [11:0] enq_off = '0;
    logic [31:0] enq_data = '0;
    logic [5:0]  enq_tag = '0;
    logic        full;
    logic        res_valid;
    logic [5:0]  res_tag;
    logic [31:0] res_data;
    logic        req_valid;
    logic        req_is_store;
    logic [11:0] req_off;
    logic        req_pair;
    logic [31:0] req_data0;
    logic [31:0] req_data1;
    logic [5:0]  req_tag0;
    logic [5:0]  req_tag1;
    logic        cache_ready = 1'b0;
    logic        flush_valid = 1'b0;
    logic [5:0]  flush_tag = '0;

    always #5 clk = ~clk;

    stack_access_queue u0 (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_is_store(enq_is_store), .enq_off(enq_off),
        .enq_data(enq_data), .enq_tag(enq_tag), .full(full),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .req_valid(req_valid), .req_is_store(req_is_store), .req_off(req_off),
        .req_pair(req_pair), .req_data0(req_data0), .req_data1(req_data1),
        .req_tag0(req_tag0), .req_tag1(req_tag1), .cache_ready(cache_ready),
        .flush_valid(flush_valid), .flush_tag(flush_tag)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model of the queue contents, oldest first.
    logic        q_st[$];
    logic [11:0] q_off[$];
    logic [31:0] q_dat[$];
    logic [5:0]  q_tag[$];
    logic        exp_rv = 1'b0;
    logic [5:0]  exp_rtag = '0;
    logic [31:0] exp_rdat = '0;
    logic [5:0]  tag_ctr = '0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic bit younger(input logic [5:0] t, input logic [5:0] f);
        logic [5:0] d;
        d = t - f;
        return (d != 0) && !d[5];
    endfunction

    function automatic bit model_pair();
        if (q_st.size() < 2) return 1'b0;
        return (q_st[0] == q_st[1]) && (q_off[1] == 12'(q_off[0] + 12'd4));
    endfunction

    // Compare all outputs with the model (R2 R5 R6 R8).
    task automatic compare_all();
        bit mv;
        bit mp;
        mv = (q_st.size() > 0) && !flush_valid;
        chk(32'(req_valid), 32'(mv), "R5 req_valid");
        if (mv) begin
            mp = model_pair();
            chk(32'(req_is_store), 32'(q_st[0]), "R5 req_is_store");
            chk(32'(req_off), 32'(q_off[0]), "R5 req_off");
            chk(32'(req_tag0), 32'(q_tag[0]), "R5 req_tag0");
            chk(req_data0, q_dat[0], "R5 req_data0");
            chk(32'(req_pair), 32'(mp), "R6 req_pair");
            if (mp) begin
                chk(32'(req_tag1), 32'(q_tag[1]), "R6 req_tag1");
                chk(req_data1, q_dat[1], "R6 req_data1");
            end
        end
        chk(32'(full), 32'(q_st.size() == 8), "R8 full");
        chk(32'(res_valid), 32'(exp_rv), "R2 res_valid");
        if (exp_rv) begin
            chk(32'(res_tag), 32'(exp_rtag), "R2 res_tag");
            chk(res_data, exp_rdat, "R2 res_data");
        end
    endtask

    // Advance the model by one clock edge using the held inputs.
    task automatic model_step();
        bit fullnow;
        bit fwd;
        bit mp;
        logic [31:0] fd;
        fullnow = (q_st.size() == 8);
        fwd = 1'b0;
        fd = '0;
        if (flush_valid) begin
            while (q_st.size() > 0 && younger(q_tag[q_tag.size()-1], flush_tag)) begin
                void'(q_st.pop_back()); void'(q_off.pop_back());
                void'(q_dat.pop_back()); void'(q_tag.pop_back());
            end
            exp_rv = 1'b0;
        end else begin
            if (enq_valid && !fullnow && !enq_is_store) begin
                for (int i = 0; i < q_st.size(); i++) begin
                    if (q_st[i] && q_off[i] == enq_off) begin
                        fwd = 1'b1;
                        fd = q_dat[i];
                    end
                end
            end
            exp_rv = fwd;
            exp_rtag = enq_tag;
            exp_rdat = fd;
            if (q_st.size() > 0 && cache_ready) begin
                mp = model_pair();
                for (int k = 0; k < (mp ? 2 : 1); k++) begin
                    void'(q_st.pop_front()); void'(q_off.pop_front());
                    void'(q_dat.pop_front()); void'(q_tag.pop_front());
                end
            end
            if (enq_valid && !fullnow && !(!enq_is_store && fwd)) begin
                q_st.push_back(enq_is_store);
                q_off.push_back(enq_off);
                q_dat.push_back(enq_is_store ? enq_data : 32'd0);
                q_tag.push_back(enq_tag);
            end
        end
    endtask

    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic enq(input logic st, input logic [11:0] off, input logic [31:0] d);
        bit acc;
        enq_valid = 1'b1;
        enq_is_store = st;
        enq_off = off;
        enq_data = d;
        enq_tag = tag_ctr;
        acc = !flush_valid && (q_st.size() < 8);
        tick();
        if (acc) tag_ctr++;
        enq_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        enq_valid = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] first;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(32'(req_valid), 0, "R1 req_valid after reset");
        chk(32'(full), 0, "R1 full after reset");
        chk(32'(res_valid), 0, "R1 res_valid after reset");
        @(negedge clk);

        // R2 R3 R4: forwarding from the youngest matching store
        cache_ready = 1'b0;
        enq(1'b1, 12'd4, 32'hA0A0_0004);
        enq(1'b1, 12'd8, 32'hB0B0_0008);
        enq(1'b1, 12'd8, 32'hC0C0_0008);
        enq(1'b0, 12'd8, 32'hDEAD_BEEF);
        chk(32'(res_valid), 1, "R2 forwarded load result");
        chk(res_data, 32'hC0C0_0008, "R3 youngest store data");
        enq(1'b0, 12'd20, 32'h1234_5678);
        chk(32'(res_valid), 0, "R4 unmatched load no result");
        chk(32'(req_pair), 1, "R6 adjacent stores paired");
        chk(req_data1, 32'hB0B0_0008, "R6 second word data");
        cache_ready = 1'b1;
        tick();
        chk(32'(req_pair), 0, "R6 mixed kinds not paired");
        tick();
        chk(32'(req_is_store), 0, "R4 queued load issued as load");
        chk(32'(req_off), 20, "R4 queued load offset");
        chk(req_data0, 0, "R4 load data field zero");
        tick();
        cache_ready = 1'b0;

        // R5 head held while cache not ready
        first = tag_ctr;
        enq(1'b1, 12'd200, 32'h0000_0200);
        idle(3);
        chk(32'(req_tag0), 32'(first), "R5 head held until ready");
        cache_ready = 1'b1;
        tick();
        cache_ready = 1'b0;

        // R6 descending and load pairs; R7 limit of two
        enq(1'b1, 12'd40, 32'h40);
        enq(1'b1, 12'd36, 32'h36);
        chk(32'(req_pair), 0, "R6 descending not paired");
        cache_ready = 1'b1;
        idle(2);
        cache_ready = 1'b0;
        enq(1'b1, 12'd0, 32'h100);
        enq(1'b1, 12'd4, 32'h104);
        enq(1'b1, 12'd8, 32'h108);
        chk(32'(req_pair), 1, "R7 first two paired");
        cache_ready = 1'b1;
        tick();
        chk(32'(req_pair), 0, "R7 third alone");
        chk(32'(req_off), 8, "R7 third offset");
        tick();
        cache_ready = 1'b0;
        enq(1'b0, 12'd48, 32'h0);
        enq(1'b0, 12'd52, 32'h0);
        chk(32'(req_pair), 1, "R6 adjacent loads paired");
        cache_ready = 1'b1;
        tick();
        cache_ready = 1'b0;

        // R8 fill and refuse
        for (int i = 0; i < 8; i++) enq(1'b1, 12'(100 + 16 * i), 32'(i));
        chk(32'(full), 1, "R8 full at eight");
        enq(1'b1, 12'd300, 32'hF00D);
        cache_ready = 1'b1;
        idle(8);
        chk(32'(req_valid), 0, "R8 refused store never issued");
        cache_ready = 1'b0;

        // R9 flush with a colliding enqueue
        first = tag_ctr;
        for (int i = 0; i < 6; i++) enq(1'b1, 12'(500 + 12 * i), 32'(i + 50));
        flush_valid = 1'b1;
        flush_tag = first + 6'd2;
        enq_valid = 1'b1;
        enq_is_store = 1'b1;
        enq_off = 12'd900;
        enq_data = 32'h9999;
        enq_tag = tag_ctr;
        #1;
        chk(32'(req_valid), 0, "R9 no request during flush");
        tick();
        flush_valid = 1'b0;
        enq_valid = 1'b0;
        chk(32'(req_tag0), 32'(first), "R9 oldest kept");
        cache_ready = 1'b1;
        idle(3);
        chk(32'(req_valid), 0, "R9 only three survive");
        cache_ready = 1'b0;

        // R10 forward from a store leaving in the same cycle
        cache_ready = 1'b1;
        enq(1'b1, 12'd64, 32'hE0E0_0064);
        enq(1'b0, 12'd64, 32'h0);
        chk(32'(res_valid), 1, "R10 forwarded while issuing");
        chk(res_data, 32'hE0E0_0064, "R10 forwarded data");
        chk(32'(req_valid), 0, "R10 load not queued");
        cache_ready = 1'b0;

        // Random traffic compared against the model every cycle
        for (int c = 0; c < 3000; c++) begin
            bit acc;
            cache_ready = ($urandom % 4) != 0;
            flush_valid = ($urandom % 40) == 0;
            flush_tag = tag_ctr - 6'd1 - 6'($urandom % 6);
            enq_valid = ($urandom % 3) != 0;
            enq_is_store = $urandom % 2;
            enq_off = 12'(4 * ($urandom % 6));
            enq_data = $urandom;
            enq_tag = tag_ctr;
            acc = enq_valid && !flush_valid && (q_st.size() < 8);
            tick();
            if (acc) tag_ctr++;
        end
        flush_valid = 1'b0;
        enq_valid = 1'b0;
        cache_ready = 1'b1;
        idle(10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule